// File: doc/BRIEF.md
# Parallel camera capture front end

This block receives a camera's parallel pixel bus together with its pixel clock and its line and frame sync lines. It runs on a faster system clock. It watches the pixel clock for the edge that software selects, and samples the data and both syncs on that edge.

A pixel is accepted only while both sync lines sit at their active (non-blanking) level. The blanking level of each sync line is programmable. The block keeps a column and a row coordinate, so it can optionally crop the image to a rectangle. It can also thin the frame stream to one frame in two or one frame in four.

Capture is started by a pulse. It then runs either continuously or for a single snapshot frame, after which it stops by itself. Accepted pixels leave on a valid/data pair. End-of-line, end-of-frame and vsync events are recorded in sticky flags. Each flag can be cleared and can be masked into one interrupt line.

Top module: `cam_capture`

## Requirements
- R1: A pixel tick is a rising `pclk` transition when `pclk_rise` is 1 and a falling one when it is 0. Syncs and data are sampled only at ticks. `pix_valid` and `pix_data` update on the same system-clock edge that sees the tick.
- R2: A sync line is active when its level differs from its blanking-level input (`hs_blank_hi`, `vs_blank_hi`). A pixel is accepted only at a tick where both syncs are active, inside a granted frame.
- R3: `width_sel` 0/1/2/3 keeps the low 8/10/12/14 bits of `pix_in` on `pix_data`, and the upper bits read zero. `pix_data` is zero whenever `pix_valid` is low.
- R4: A frame starts at a tick where vsync becomes active. With `rate_sel` 1, only every second frame start since capture was enabled is granted; with 2, only every fourth; with 0 or 3, every frame. The first frame start after capture is enabled is always granted.
- R5: With `snap_mode` 1, one granted frame is captured. `capture_on` then drops on the cycle where that frame's vsync returns to blanking.
- R6: With `snap_mode` 0, a `cap_start` pulse sets `capture_on`, which stays high across frames until a `cap_stop` pulse. `cap_start` wins if both are pulsed together.
- R7: With `win_en` 1, a pixel is output only if its column lies in [`win_hstart`, `win_hstart`+`win_hsize`) and its row lies in [`win_vstart`, `win_vstart`+`win_vsize`). Columns count from 0 at the first active tick of a line. Rows count from 0 at the frame start and advance at each line end.
- R8: `flags[0]` (end of line) sets when hsync leaves the active level while vsync is active, within a granted frame.
- R9: `flags[1]` (end of frame) sets when vsync returns to blanking, but only at the end of a granted frame.
- R10: `flags[2]` (vsync) sets whenever vsync returns to blanking, whether or not the frame was granted.
- R11: Flags are sticky. A 1 on a bit of `flag_clr` clears that flag, unless the flag is set on the same cycle, in which case setting wins. `irq` is high while any flag is set together with its `irq_en` bit.
- R12: While `enable` is low, all flags and counters are cleared, capture is cancelled, and no pixel is output.
- R13: During reset, `pix_valid`, `pix_data`, `flags`, `capture_on` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; low holds the block cleared |
| pclk | input | 1 | Camera pixel clock, sampled by `clk` |
| hsync | input | 1 | Line sync from the camera |
| vsync | input | 1 | Frame sync from the camera |
| pix_in | input | DW | Parallel pixel data |
| pclk_rise | input | 1 | 1: sample on rising pixel-clock edge, 0: falling |
| hs_blank_hi | input | 1 | Level of hsync during blanking |
| vs_blank_hi | input | 1 | Level of vsync during blanking |
| rate_sel | input | 2 | Frame decimation: 0 all, 1 one in two, 2 one in four |
| width_sel | input | 2 | Data width: 0/1/2/3 = 8/10/12/14 bits |
| snap_mode | input | 1 | 1: single-frame capture, 0: continuous |
| cap_start | input | 1 | Pulse that arms capture |
| cap_stop | input | 1 | Pulse that disarms capture |
| win_en | input | 1 | Enables the cropping rectangle |
| win_hstart | input | HW | First column of the rectangle |
| win_hsize | input | HW | Column count of the rectangle |
| win_vstart | input | VSW | First row of the rectangle |
| win_vsize | input | VW | Row count of the rectangle |
| irq_en | input | 3 | Per-flag interrupt enables |
| flag_clr | input | 3 | Per-flag clear strobes |
| pix_valid | output | 1 | Pixel accepted this cycle |
| pix_data | output | DW | Accepted pixel, zero-extended |
| capture_on | output | 1 | Capture armed |
| flags | output | 3 | Sticky flags: bit 0 line end, bit 1 frame end, bit 2 vsync |
| irq | output | 1 | Combined interrupt |

## Verification
Each pixel-clock edge is seen one system-clock edge after the bench moves `pclk`. The pixel output, the flags and the capture state all change on that same system-clock edge, and `irq` follows the flags in the same cycle with no added delay.

The bench moves inputs on falling system-clock edges. On every posedge it advances a behavioural model from the same inputs, then compares every output with the model on the next falling edge. In this way each expected value is checked in exactly the cycle it becomes due. Directed checks of pixel counts, frame-end counts and flag values are taken after whole frames, once all these results have settled.

// File: rtl/cam_capture.sv
module cam_capture #(
  parameter int DW  = 14,
  parameter int HW  = 14,
  parameter int VSW = 13,
  parameter int VW  = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           pclk,
  input  logic           hsync,
  input  logic           vsync,
  input  logic [DW-1:0]  pix_in,
  input  logic           pclk_rise,
  input  logic           hs_blank_hi,
  input  logic           vs_blank_hi,
  input  logic [1:0]     rate_sel,
  input  logic [1:0]     width_sel,
  input  logic           snap_mode,
  input  logic           cap_start,
  input  logic           cap_stop,
  input  logic           win_en,
  input  logic [HW-1:0]  win_hstart,
  input  logic [HW-1:0]  win_hsize,
  input  logic [VSW-1:0] win_vstart,
  input  logic [VW-1:0]  win_vsize,
  input  logic [2:0]     irq_en,
  input  logic [2:0]     flag_clr,
  output logic           pix_valid,
  output logic [DW-1:0]  pix_data,
  output logic           capture_on,
  output logic [2:0]     flags,
  output logic           irq
);

  logic          pclk_q, h_q, v_q, grab, cap_en;
  logic [1:0]    fcnt;
  logic [HW-1:0] col;
  logic [VW-1:0] row;
  logic [DW-1:0] keep_mask;

  wire tick  = pclk_rise ? (pclk & ~pclk_q) : (~pclk & pclk_q);
  wire h_act = hsync ^ hs_blank_hi;
  wire v_act = vsync ^ vs_blank_hi;

  wire v_rise = tick & v_act & ~v_q;
  wire v_fall = tick & ~v_act & v_q;
  wire l_end  = tick & ~h_act & h_q & v_act;

  wire keep = (rate_sel == 2'd1) ? ~fcnt[0] :
              (rate_sel == 2'd2) ? (fcnt == 2'd0) : 1'b1;
  wire go   = v_rise ? (cap_en & keep) : grab;

  wire [HW-1:0] ccol = h_q ? col : '0;
  wire [VW-1:0] crow = v_rise ? '0 : row;

  wire [HW:0] col_x = {1'b0, ccol};
  wire [HW:0] hs_x  = {1'b0, win_hstart};
  wire [HW:0] he_x  = hs_x + {1'b0, win_hsize};
  wire [VW:0] row_x = {1'b0, crow};
  wire [VW:0] vs_x  = {{(VW + 1 - VSW){1'b0}}, win_vstart};
  wire [VW:0] ve_x  = vs_x + {1'b0, win_vsize};

  wire in_win = (col_x >= hs_x) && (col_x < he_x) && (row_x >= vs_x) && (row_x < ve_x);
  wire take   = tick & h_act & v_act & go & (~win_en | in_win);
  wire snap_done = v_fall & grab & snap_mode;

  always_comb
    for (int i = 0; i < DW; i++)
      keep_mask[i] = (i < 8 + 2 * int'(width_sel));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pclk_q <= 1'b0;
      h_q    <= 1'b0;
      v_q    <= 1'b0;
    end else begin
      pclk_q <= pclk;
      if (tick) begin
        h_q <= h_act;
        v_q <= v_act;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_en    <= 1'b0;
      grab      <= 1'b0;
      fcnt      <= '0;
      col       <= '0;
      row       <= '0;
      flags     <= '0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else if (!enable) begin
      cap_en    <= 1'b0;
      grab      <= 1'b0;
      fcnt      <= '0;
      col       <= '0;
      row       <= '0;
      flags     <= '0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      cap_en <= (cap_en & ~cap_stop & ~snap_done) | cap_start;
      if (!cap_en)     fcnt <= '0;
      else if (v_rise) fcnt <= fcnt + 2'd1;
      if (v_rise)      grab <= cap_en & keep;
      else if (v_fall) grab <= 1'b0;
      if (tick & h_act & v_act) col <= ccol + 1'b1;
      if (l_end)       row <= crow + 1'b1;
      else if (v_rise) row <= '0;
      flags     <= (flags & ~flag_clr) | {v_fall, v_fall & grab, l_end & go};
      pix_valid <= take;
      pix_data  <= take ? (pix_in & keep_mask) : '0;
    end

  assign capture_on = cap_en;
  assign irq        = |(flags & irq_en);

endmodule

module cam_capture_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          snap_mode,
  input logic          cap_stop,
  input logic [1:0]    width_sel,
  input logic [2:0]    flag_clr,
  input logic          pix_valid,
  input logic [DW-1:0] pix_data,
  input logic          capture_on,
  input logic [2:0]    flags
);

  // R12
  valid_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(enable));

  // R12
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (flags == 3'b000) && !capture_on);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> (($past(flags) & ~$past(flag_clr) & ~flags) == 3'b000));

  // R5
  snap_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(capture_on) && $past(snap_mode) && $past(enable) && !$past(cap_stop) |-> flags[1]);

  // R3
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && ($past(width_sel) == 2'd0) |-> (pix_data[DW-1:8] == '0));

endmodule

bind cam_capture cam_capture_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .snap_mode(snap_mode),
  .cap_stop(cap_stop), .width_sel(width_sel), .flag_clr(flag_clr),
  .pix_valid(pix_valid), .pix_data(pix_data), .capture_on(capture_on), .flags(flags)
);

// File: tb/tb_cam_capture.sv
module tb_cam_capture;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, enable, pclk, hsync, vsync;
  logic [13:0] pix_in;
  logic        pclk_rise, hs_blank_hi, vs_blank_hi;
  logic [1:0]  rate_sel, width_sel;
  logic        snap_mode, cap_start, cap_stop, win_en;
  logic [13:0] win_hstart, win_hsize, win_vsize;
  logic [12:0] win_vstart;
  logic [2:0]  irq_en, flag_clr;
  logic        pix_valid, capture_on, irq;
  logic [13:0] pix_data;
  logic [2:0]  flags;

  cam_capture dut (.*);

  int    vectors = 0, errs = 0, npix = 0, neof = 0;
  string req = "R13";
  bit    prev_eof = 0;

  bit       m_pp, m_hp, m_vp, m_grab, m_cap, m_valid;
  bit [2:0] m_flags;
  int       m_col, m_row, m_frames, m_data;

  task automatic clear_model();
    m_col = 0; m_row = 0; m_frames = 0; m_grab = 0; m_cap = 0;
    m_flags = 0; m_valid = 0; m_data = 0;
  endtask

  always @(posedge clk) begin
    bit t, ha, va, vr, vf, le, go, kp, tk, done;
    int cc, cr, lim;
    if (!rst_n) begin
      m_pp = 0; m_hp = 0; m_vp = 0;
      clear_model();
    end else begin
      t  = pclk_rise ? (pclk && !m_pp) : (!pclk && m_pp);
      m_pp = pclk;
      ha = (hsync != hs_blank_hi);
      va = (vsync != vs_blank_hi);
      vr = t && va && !m_vp;
      vf = t && !va && m_vp;
      le = t && !ha && m_hp && va;
      case (rate_sel)
        2'd1: kp = (m_frames % 2) == 0;
        2'd2: kp = (m_frames % 4) == 0;
        default: kp = 1;
      endcase
      go = vr ? (m_cap && kp) : m_grab;
      cc = m_hp ? m_col : 0;
      cr = vr ? 0 : m_row;
      tk = t && ha && va && go &&
           (!win_en || (cc >= int'(win_hstart) && cc < int'(win_hstart) + int'(win_hsize) &&
                        cr >= int'(win_vstart) && cr < int'(win_vstart) + int'(win_vsize)));
      lim = 1 << (8 + 2 * int'(width_sel));
      if (t) begin m_hp = ha; m_vp = va; end
      if (!enable) clear_model();
      else begin
        done    = vf && m_grab && snap_mode;
        m_flags = (m_flags & ~flag_clr) | {vf, vf && m_grab, le && go};
        m_valid = tk;
        m_data  = tk ? int'(pix_in) % lim : 0;
        if (t && ha && va) m_col = cc + 1;
        if (le) m_row = cr + 1; else if (vr) m_row = 0;
        if (vr) m_grab = m_cap && kp; else if (vf) m_grab = 0;
        if (!m_cap) m_frames = 0; else if (vr) m_frames++;
        m_cap = (m_cap && !cap_stop && !done) || cap_start;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    vectors++;
    if (pix_valid !== m_valid || pix_data !== m_data[13:0] || flags !== m_flags ||
        capture_on !== m_cap || irq !== |(m_flags & irq_en)) begin
      errs++;
      $display("FAIL %s: valid/data/flags/cap/irq = %b/%h/%b/%b/%b expected %b/%h/%b/%b/%b",
               req, pix_valid, pix_data, flags, capture_on, irq,
               m_valid, m_data[13:0], m_flags, m_cap, |(m_flags & irq_en));
    end
    if (pix_valid) npix++;
    if (flags[1] && !prev_eof) neof++;
    prev_eof = flags[1];
  end

  task automatic chk(string r, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic pix(bit h, bit v, logic [13:0] d);
    @(negedge clk);
    pclk = !pclk_rise; hsync = h ^ hs_blank_hi; vsync = v ^ vs_blank_hi; pix_in = d;
    repeat (2) @(negedge clk);
    pclk = pclk_rise;
    @(negedge clk);
  endtask

  task automatic frame(int rows, int cols);
    repeat (3) pix(0, 0, 14'h0);
    for (int r = 0; r < rows; r++) begin
      pix(0, 1, 14'h0);
      for (int c = 0; c < cols; c++) pix(1, 1, 14'((r * 53 + c * 97 + 11) ^ 16'h2A85));
      pix(0, 1, 14'h0);
    end
    pix(0, 0, 14'h0);
  endtask

  task automatic pulse_start(); @(negedge clk) cap_start = 1; @(negedge clk) cap_start = 0; endtask
  task automatic pulse_stop();  @(negedge clk) cap_stop = 1;  @(negedge clk) cap_stop = 0;  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; enable = 0; pclk = 0; hsync = 0; vsync = 0; pix_in = 0;
    pclk_rise = 1; hs_blank_hi = 0; vs_blank_hi = 0; rate_sel = 0; width_sel = 3;
    snap_mode = 0; cap_start = 0; cap_stop = 0; win_en = 0;
    win_hstart = 0; win_hsize = 0; win_vstart = 0; win_vsize = 0;
    irq_en = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    chk("R13", {pix_valid, capture_on, irq, flags}, 0);
    chk("R13", pix_data, 0);
    rst_n = 1; enable = 1;

    req = "R6"; npix = 0;
    pulse_start();
    frame(3, 4); frame(3, 4);
    chk("R6", npix, 24);
    chk("R6", capture_on, 1);

    req = "R2"; npix = 0;
    repeat (5) pix(1, 0, 14'h155);
    chk("R2", npix, 0);

    req = "R1"; npix = 0;
    pclk_rise = 0; hs_blank_hi = 1; vs_blank_hi = 1;
    repeat (2) pix(0, 0, 14'h0);
    npix = 0;
    frame(2, 3);
    chk("R1", npix, 6);
    pclk_rise = 1; hs_blank_hi = 0; vs_blank_hi = 0;
    repeat (2) pix(0, 0, 14'h0);

    req = "R3";
    for (int w = 0; w < 3; w++) begin
      width_sel = 2'(w); npix = 0;
      frame(1, 4);
      chk("R3", npix, 4);
    end
    width_sel = 3;

    req = "R4"; flag_clr = 3'b111;
    pulse_stop(); rate_sel = 1; pulse_start();
    npix = 0; neof = 0;
    repeat (4) frame(2, 2);
    chk("R4", npix, 8);
    chk("R9", neof, 2);
    pulse_stop(); rate_sel = 2; pulse_start();
    npix = 0; neof = 0;
    repeat (4) frame(2, 2);
    chk("R4", npix, 4);
    chk("R9", neof, 1);
    rate_sel = 0;

    req = "R5";
    pulse_stop(); snap_mode = 1; pulse_start();
    npix = 0; neof = 0;
    frame(2, 2); frame(2, 2);
    chk("R5", npix, 4);
    chk("R5", neof, 1);
    chk("R5", capture_on, 0);
    snap_mode = 0;

    req = "R7";
    win_en = 1; win_hstart = 1; win_hsize = 2; win_vstart = 1; win_vsize = 2;
    pulse_start(); npix = 0;
    frame(4, 4);
    chk("R7", npix, 4);
    win_en = 0;

    req = "R8"; flag_clr = 0; irq_en = 0;
    frame(1, 2);
    chk("R8", flags, 3'b111);
    chk("R11", irq, 0);
    @(negedge clk) irq_en = 3'b010;
    @(negedge clk);
    chk("R11", irq, 1);
    flag_clr = 3'b010;
    @(negedge clk) flag_clr = 0;
    @(negedge clk);
    chk("R11", flags, 3'b101);
    chk("R11", irq, 0);

    req = "R10";
    pulse_stop();
    @(negedge clk) flag_clr = 3'b111;
    @(negedge clk) flag_clr = 0;
    npix = 0;
    frame(2, 2);
    chk("R10", flags, 3'b100);
    chk("R10", npix, 0);

    req = "R12";
    pulse_start();
    frame(1, 2);
    enable = 0;
    @(negedge clk);
    chk("R12", {flags, capture_on}, 0);
    npix = 0;
    frame(2, 2);
    chk("R12", npix, 0);
    chk("R12", flags, 0);
    enable = 1;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule